// File: doc/BRIEF.md
# Dual I/O Fast-Read Engine

This block is the read path of a serial flash slave. It takes the serial clock, the active-low select and two data lines from a host. It decodes four read commands and collects a 24-bit start address. For two of the commands it also waits through a fixed run of dummy clocks. It then streams bytes back on one or two lines, MSB first, with per-line output enables. Bytes come from a memory array through a simple request/data port. The byte address advances after each byte until the host raises select.

All pins are sampled into the system clock domain through a parameterised synchroniser. Serial clock edges are found in that domain, so every action happens on a system clock edge. For the dual I/O command, the address and an 8-bit mode field arrive two bits per serial clock. When mode bits 5:4 read binary 10, the engine enters a continuous state. In that state the next select period skips the opcode and begins directly with the address.

Top module: `dio_read_engine`

## Requirements
- R1: While reset is held and right after it is released, `dq_oe` is 00 and `rd_req` is 0.
- R2: The opcode is the first 8 bits taken MSB first from `dq_in[0]` on rising serial clocks. The read opcodes are 03h, 0Bh, 3Bh and BBh. Any other value leaves `dq_oe` at 00 until select rises.
- R3: For 03h, the MSB of the first byte is driven on the falling serial clock that follows the 24th address bit. There are no dummy clocks.
- R4: For 0Bh and 3Bh, 8 dummy clocks follow the address. `dq_oe` stays 00 during them, and data starts on the falling edge after the 8th.
- R5: Single-line commands (03h, 0Bh) drive data only on `dq_out[1]` with `dq_oe` = 10. Each byte takes 8 clocks, MSB first.
- R6: Dual-line commands (3Bh, BBh) use `dq_oe` = 11. Each byte takes 4 clocks: `dq_out[1]` carries D7, D5, D3, D1 and `dq_out[0]` carries D6, D4, D2, D0.
- R7: For BBh, 24 address bits and then 8 mode bits arrive over 16 rising clocks. `dq_in[1]` carries the odd-numbered bits and `dq_in[0]` the even ones. Data follows with no dummy clocks.
- R8: A BBh whose mode bits 5:4 equal binary 10 makes the next select period start with the BBh address phase and no opcode. Any other mode value restores opcode decoding.
- R9: The byte address increments after each byte. With the default `ADDR_W` = 19 it wraps from 7FFFFh to 00000h.
- R10: Outputs and output enables change only after a falling serial clock. Data held during a serial clock high phase keeps its value.
- R11: Whenever select is high, `dq_oe` is 00.
- R12: If `busy` is 1 when the last address bit arrives, the command is dropped. `dq_oe` stays 00 and the mode bits are not applied.
- R13: `rd_req` is a one-cycle pulse with `rd_addr` valid. `rd_data` is taken on the following cycle. Each transaction makes one request at the start and one per byte loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| dq_in | input | 2 | Serial data lines as seen by the slave |
| busy | input | 1 | Array busy with a program or erase cycle |
| dq_out | output | 2 | Serial data driven by the slave |
| dq_oe | output | 2 | Per-line output enable |
| rd_req | output | 1 | Array read request pulse |
| rd_addr | output | ADDR_W | Array byte address |
| rd_data | input | 8 | Array byte, valid the cycle after `rd_req` |

## Verification
A serial clock edge passes through two synchroniser stages and one edge register before any action. Outputs therefore settle on the third system clock after the host moves `sck`. The bench holds each serial level for six system clocks and reads outputs four clocks after a falling edge. That sample point is later than the settling time and earlier than the next rising edge. The hold check for R10 reads four clocks into a high phase, which is also before the next falling edge takes effect. The array model answers one cycle after each request. The engine asks for a byte at least four serial clocks before it needs it, so prefetch is never on the critical path.

// File: rtl/dio_rd_pkg.sv
package dio_rd_pkg;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_DATA,
      PH_IDLE
   } phase_t;

   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_FAST  = 8'h0B;
   localparam logic [7:0] OP_DOUT  = 8'h3B;
   localparam logic [7:0] OP_DIO   = 8'hBB;
   localparam logic [1:0] CONT_KEY = 2'b10;

   function automatic logic is_read(input logic [7:0] op);
      return (op == OP_READ) || (op == OP_FAST) || (op == OP_DOUT) || (op == OP_DIO);
   endfunction

endpackage

// File: rtl/dio_rd_sync.sv
module dio_rd_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dio_rd_seq.sv
module dio_rd_seq
   import dio_rd_pkg::*;
#(
   parameter int DUMMY_CLKS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_idle,
   input  logic        rise,
   input  logic        busy,
   input  logic [1:0]  din,
   output logic        in_data,
   output logic        dual,
   output logic        start,
   output logic [23:0] start_addr,
   output logic        cont_mode
);

   localparam int CNT_MAX = (DUMMY_CLKS > 24) ? DUMMY_CLKS : 24;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   phase_t           ph;
   logic [CNT_W-1:0] cnt;
   logic [31:0]      sh;
   logic [31:0]      sh_nxt;
   logic [7:0]       op;
   logic [7:0]       op_nxt;
   logic             dio;
   logic             addr_last;
   logic             wants_dummy;

   always_comb begin
      dio         = (op == OP_DIO);
      sh_nxt      = dio ? {sh[29:0], din[1], din[0]} : {sh[30:0], din[0]};
      op_nxt      = {sh[6:0], din[0]};
      addr_last   = dio ? (cnt == CNT_W'(15)) : (cnt == CNT_W'(23));
      wants_dummy = (op == OP_FAST) || (op == OP_DOUT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_CMD;
         cnt        <= '0;
         sh         <= '0;
         op         <= '0;
         cont_mode  <= 1'b0;
         start      <= 1'b0;
         start_addr <= '0;
      end else begin
         start <= 1'b0;
         if (cs_idle) begin
            ph  <= cont_mode ? PH_ADDR : PH_CMD;
            op  <= cont_mode ? OP_DIO : 8'h00;
            cnt <= '0;
         end else if (rise) begin
            unique case (ph)
               PH_CMD: begin
                  sh <= sh_nxt;
                  if (cnt == CNT_W'(7)) begin
                     cnt <= '0;
                     op  <= op_nxt;
                     ph  <= is_read(op_nxt) ? PH_ADDR : PH_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_ADDR: begin
                  sh <= sh_nxt;
                  if (addr_last) begin
                     cnt        <= '0;
                     start_addr <= dio ? sh_nxt[31:8] : sh_nxt[23:0];
                     if (busy) begin
                        ph <= PH_IDLE;
                     end else begin
                        if (dio) cont_mode <= (sh_nxt[5:4] == CONT_KEY);
                        if (wants_dummy) begin
                           ph <= PH_DUMMY;
                        end else begin
                           ph    <= PH_DATA;
                           start <= 1'b1;
                        end
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_DUMMY: begin
                  if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
                     cnt   <= '0;
                     ph    <= PH_DATA;
                     start <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign in_data = (ph == PH_DATA);
   assign dual    = (op == OP_DOUT) || dio;

endmodule

// File: rtl/dio_rd_ser.sv
module dio_rd_ser #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle,
   input  logic              fall,
   input  logic              active,
   input  logic              dual,
   input  logic              start,
   input  logic [23:0]       start_addr,
   input  logic [7:0]        rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        dq_out,
   output logic [1:0]        dq_oe
);

   logic [7:0] nxt;
   logic [7:0] shr;
   logic [2:0] bitpos;
   logic [2:0] last_pos;
   logic [1:0] oe;
   logic       req_d;

   assign last_pos = dual ? 3'd3 : 3'd7;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt     <= '0;
         shr     <= '0;
         bitpos  <= '0;
         oe      <= '0;
         req_d   <= 1'b0;
         rd_req  <= 1'b0;
         rd_addr <= '0;
         dq_out  <= '0;
      end else begin
         rd_req <= 1'b0;
         req_d  <= rd_req;
         if (req_d) nxt <= rd_data;
         if (cs_idle) begin
            oe     <= '0;
            bitpos <= '0;
         end else if (start) begin
            rd_addr <= start_addr[ADDR_W-1:0];
            rd_req  <= 1'b1;
            bitpos  <= '0;
         end else if (fall && active) begin
            if (bitpos == 3'd0) begin
               shr     <= dual ? {nxt[5:0], 2'b00} : {nxt[6:0], 1'b0};
               dq_out  <= dual ? nxt[7:6] : {nxt[7], 1'b0};
               oe      <= dual ? 2'b11 : 2'b10;
               rd_addr <= rd_addr + 1'b1;
               rd_req  <= 1'b1;
            end else begin
               dq_out <= dual ? shr[7:6] : {shr[7], 1'b0};
               shr    <= dual ? {shr[5:0], 2'b00} : {shr[6:0], 1'b0};
            end
            bitpos <= (bitpos == last_pos) ? 3'd0 : bitpos + 3'd1;
         end
      end
   end

   assign dq_oe = oe & {2{~cs_idle}};

endmodule

// File: rtl/dio_read_engine.sv
module dio_read_engine #(
   parameter int ADDR_W      = 19,
   parameter int DUMMY_CLKS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic [1:0]        dq_in,
   input  logic              busy,
   output logic [1:0]        dq_out,
   output logic [1:0]        dq_oe,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 24) else $fatal(1, "ADDR_W must lie in 1..24");
      assert (DUMMY_CLKS >= 1) else $fatal(1, "DUMMY_CLKS must be at least 1");
      assert (SYNC_STAGES >= 0) else $fatal(1, "SYNC_STAGES must not be negative");
   end

   logic [3:0] pins_s;
   logic       cs_idle;
   logic       sck_s;
   logic       sck_d;
   logic [1:0] din_s;
   logic       rise;
   logic       fall;
   logic       in_data;
   logic       dual;
   logic       start;
   logic       cont_mode;
   logic [23:0] start_addr;

   dio_rd_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b1000)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, dq_in}),
      .q     (pins_s)
   );

   assign cs_idle = pins_s[3];
   assign sck_s   = pins_s[2];
   assign din_s   = pins_s[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;

   dio_rd_seq #(.DUMMY_CLKS(DUMMY_CLKS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (cs_idle),
      .rise       (rise),
      .busy       (busy),
      .din        (din_s),
      .in_data    (in_data),
      .dual       (dual),
      .start      (start),
      .start_addr (start_addr),
      .cont_mode  (cont_mode)
   );

   dio_rd_ser #(.ADDR_W(ADDR_W)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (cs_idle),
      .fall       (fall),
      .active     (in_data),
      .dual       (dual),
      .start      (start),
      .start_addr (start_addr),
      .rd_data    (rd_data),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .dq_out     (dq_out),
      .dq_oe      (dq_oe)
   );

endmodule

// File: rtl/dio_rd_checker.sv
module dio_rd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       fall,
   input logic       rd_req,
   input logic [1:0] dq_out,
   input logic [1:0] dq_oe
);

   assert_out_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dq_out) |-> $past(fall));

   assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe[1]) |-> $past(fall));

   assert_dq0_needs_dq1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[0] |-> dq_oe[1]);

   assert_req_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

endmodule

bind dio_read_engine dio_rd_checker u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .fall   (fall),
   .rd_req (rd_req),
   .dq_out (dq_out),
   .dq_oe  (dq_oe)
);

// File: tb/sim_dio_read_engine.sv
module sim_dio_read_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic [1:0]  dq_in = 2'b00;
   logic        busy = 1'b0;
   logic [1:0]  dq_out;
   logic [1:0]  dq_oe;
   logic        rd_req;
   logic [18:0] rd_addr;
   logic [7:0]  rd_data = 8'h00;

   int errors = 0;
   int checks = 0;
   int req_cnt = 0;
   logic [1:0] lq, loe;

   always #2 clk = ~clk;

   dio_read_engine u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq_in(dq_in), .busy(busy),
      .dq_out(dq_out), .dq_oe(dq_oe), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [7:0] pat(input logic [18:0] a);
      return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      if (rd_req) begin
         rd_data <= pat(rd_addr);
         req_cnt <= req_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [1:0] d);
      dq_in = d;
      repeat (6) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
      lq = dq_out;
      loe = dq_oe;
      repeat (2) @(negedge clk);
   endtask

   task automatic cs_begin();
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_end();
      cs_n = 1'b1;
      dq_in = 2'b00;
      repeat (8) @(negedge clk);
      chk("R11 oe released with select high", dq_oe, 2'b00);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) pulse({1'b0, b[i]});
   endtask

   task automatic send_addr(input logic [23:0] a);
      for (int i = 23; i >= 0; i--) pulse({1'b0, a[i]});
   endtask

   task automatic send_dual(input logic [31:0] w);
      for (int i = 15; i >= 0; i--) pulse({w[2*i+1], w[2*i]});
   endtask

   task automatic dummies();
      logic bad;
      bad = 1'b0;
      for (int i = 0; i < 7; i++) begin
         pulse(2'b00);
         if (loe !== 2'b00) bad = 1'b1;
      end
      chk("R4 lines released in dummy clocks", bad, 1'b0);
      pulse(2'b00);
   endtask

   task automatic read_single(input int n, input logic [18:0] a, input string tag);
      logic [7:0] got;
      for (int k = 0; k < n; k++) begin
         chk({tag, " R5 single enable"}, loe, 2'b10);
         got[7] = lq[1];
         for (int b = 6; b >= 0; b--) begin
            pulse(2'b00);
            got[b] = lq[1];
         end
         chk({tag, " data byte"}, got, pat(a + 19'(k)));
         pulse(2'b00);
      end
   endtask

   task automatic read_dual(input int n, input logic [18:0] a, input string tag);
      logic [7:0] got;
      for (int k = 0; k < n; k++) begin
         chk({tag, " R6 dual enable"}, loe, 2'b11);
         got[7:6] = lq;
         for (int b = 2; b >= 0; b--) begin
            pulse(2'b00);
            got[2*b+1 -: 2] = lq;
         end
         chk({tag, " data byte"}, got, pat(a + 19'(k)));
         pulse(2'b00);
      end
   endtask

   task automatic t_reset();
      chk("R1 oe after reset", dq_oe, 2'b00);
      chk("R1 no request after reset", rd_req, 1'b0);
   endtask

   task automatic t_read();
      cs_begin();
      req_cnt = 0;
      send_byte(8'h03);
      send_addr(24'h012345);
      read_single(3, 19'h12345, "R3 R9 read 03h");
      chk("R13 request count", req_cnt, 5);
      cs_end();
   endtask

   task automatic t_fast();
      cs_begin();
      send_byte(8'h0B);
      send_addr(24'h000100);
      dummies();
      read_single(2, 19'h00100, "R4 fast 0Bh");
      cs_end();
   endtask

   task automatic t_dout();
      cs_begin();
      send_byte(8'h3B);
      send_addr(24'h02ABCD);
      dummies();
      read_dual(3, 19'h2ABCD, "R6 dual out 3Bh");
      cs_end();
   endtask

   task automatic t_dio_cont();
      cs_begin();
      send_byte(8'hBB);
      send_dual({24'h031111, 8'hA0});
      read_dual(2, 19'h31111, "R7 dual io BBh");
      cs_end();
      cs_begin();
      send_dual({24'h004000, 8'h00});
      read_dual(2, 19'h04000, "R8 continuous no opcode");
      cs_end();
      cs_begin();
      send_dual({24'h005000, 8'hA0});
      chk("R8 opcode decode restored", loe, 2'b00);
      cs_end();
   endtask

   task automatic t_wrap();
      cs_begin();
      send_byte(8'h03);
      send_addr(24'h07FFFF);
      read_single(2, 19'h7FFFF, "R9 wrap");
      cs_end();
   endtask

   task automatic t_busy();
      logic bad;
      bad = 1'b0;
      busy = 1'b1;
      cs_begin();
      send_byte(8'h03);
      send_addr(24'h000010);
      if (loe !== 2'b00) bad = 1'b1;
      for (int i = 0; i < 10; i++) begin
         pulse(2'b00);
         if (loe !== 2'b00) bad = 1'b1;
      end
      chk("R12 busy read ignored", bad, 1'b0);
      cs_end();
      busy = 1'b0;
   endtask

   task automatic t_bad_op();
      logic bad;
      bad = 1'b0;
      cs_begin();
      send_byte(8'h05);
      for (int i = 0; i < 32; i++) begin
         pulse(2'b11);
         if (loe !== 2'b00) bad = 1'b1;
      end
      chk("R2 unknown opcode silent", bad, 1'b0);
      cs_end();
   endtask

   task automatic t_hold_high();
      logic [7:0] e;
      e = pat(19'h00200);
      cs_begin();
      send_byte(8'h03);
      send_addr(24'h000200);
      chk("R3 first bit after address", lq[1], e[7]);
      dq_in = 2'b00;
      repeat (6) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 data held through rising edge", dq_out[1], e[7]);
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 next bit after falling edge", dq_out[1], e[6]);
      cs_end();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_read();
      t_fast();
      t_dout();
      t_dio_cont();
      t_wrap();
      t_busy();
      t_bad_op();
      t_hold_high();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule